// File: doc/BRIEF.md
# Data Translation Lookaside Buffer with Fault Status

This block translates data-side virtual addresses for a processor core. It holds a fully associative set of translation entries. Each entry has a virtual tag, a context number and a 64-bit page-table word. Every cycle it can accept one lookup request. A request carries a virtual address, an access kind (load, store or no-fault load), a context selector (primary, secondary or nucleus), a user-mode flag and a privileged-mode flag. All valid entries are compared at once. Each comparison uses that entry's own page size.

The result comes back one clock after the request. A clean hit returns a physical address together with read and write grants. A hit that breaks a page attribute raises either a data-fault trap or a protection trap, and records the cause in a sticky fault status register and a fault address register. A lookup that matches no entry raises a miss trap. It loads only the tag-access register, so that a refill handler can find the page. Entries are written by an external refill agent through a write port, and any entry can be read back through a read port. Choosing which entry to replace and walking the page tables are done outside the block.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the fault status, fault address and tag-access registers are all zero. Every entry is invalid, so the first lookup misses.
- R2: An entry hits when its bit 63 (valid) is set, its stored context equals the request context, and its virtual tag equals the request address above the page offset. The request context is `ctx_primary` when `req_ctx_sel` is 0, `ctx_secondary` when it is 1, and 0 when it is 2 or 3. The response appears on the ports one clock after the request is sampled.
- R3: Entry bits 62:61 hold the page size. Codes 0, 1, 2 and 3 give 13, 16, 19 and 22 offset bits. The physical address is entry bits 40:13 above the offset, with the request address below the offset.
- R4: A hit with no fault grants read, and grants write exactly when entry bit 1 is set. It also sets entry bit 41 (used). Any trap gives no grants and a zero physical address. Trap codes are: 0 none, 1 data fault, 2 protection, 3 miss.
- R5: There are three data-fault causes. A user access to a page with bit 2 set sets status bit 7. A no-fault load (`req_kind` 2) to a page with bit 3 set sets status bit 8. A load or store (`req_kind` 0, 1 or 3; 3 acts as a load) to a page with bit 60 set sets status bit 9. Causes combine, and any one of them gives trap 1.
- R6: A store (`req_kind` 1) to a page with bit 1 clear gives trap 2, but only when no data-fault cause applies. Status bits 10:7 are then zero.
- R7: A data fault or protection fault overwrites the status register as follows. Bit 0 is set. Bit 2 marks a store. Bit 3 copies `req_priv`. Bit 4 marks a no-fault load. Bits 6:5 give the context type (0 primary, 1 secondary, 2 nucleus). The fault address register takes the full virtual address.
- R8: A fault recorded while status bit 0 is already set also sets overflow bit 1. Otherwise bit 1 is cleared.
- R9: A `fstat_rd` pulse clears status bit 0 at the next edge. If a fault is recorded in the same cycle, the fault is still written with bit 0 set, and overflow is not set.
- R10: A miss gives trap 3 and loads the tag-access register with the virtual address, whose low 13 bits are replaced by the request context. The status and fault address registers keep their values.
- R11: When several entries hit, the entry with the lowest index supplies the result.
- R12: `ent_wr_en` replaces entry `ent_wr_idx` at the next edge. A lookup in the same cycle sees the old contents. `ent_rd_tte` shows the page-table word of entry `ent_rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_primary | input | CTX_W | Primary context number |
| ctx_secondary | input | CTX_W | Secondary context number |
| req_valid | input | 1 | Lookup request present |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 no-fault load, 3 load |
| req_ctx_sel | input | 2 | 0 primary, 1 secondary, 2/3 nucleus |
| req_user | input | 1 | Access is in user mode |
| req_priv | input | 1 | Processor privileged-mode flag for the status |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_idx | input | IDX_W | Entry to write |
| ent_wr_va | input | VA_W | Virtual tag to store |
| ent_wr_ctx | input | CTX_W | Context to store |
| ent_wr_tte | input | 64 | Page-table word to store |
| ent_rd_idx | input | IDX_W | Entry to read back |
| ent_rd_tte | output | 64 | Page-table word of the selected entry |
| fstat_rd | input | 1 | Status read strobe; clears the valid bit |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 2 | Trap code |
| rsp_pa | output | PA_W | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| fstat_q | output | 11 | Fault status register |
| faddr_q | output | VA_W | Fault address register |
| tacc_q | output | VA_W | Tag-access register |

## Verification
Two functions can land on the same status register in the same cycle: a status read strobe and the recording of a new fault. The bench provokes this in two steps. First it stacks two faults with no read in between, and expects the overflow bit to be set. Then it raises `fstat_rd` in the very cycle that a store hits a no-fault-only page, and expects the new cause written with the valid bit set and the overflow bit clear. A second collision occurs when an entry is rewritten in the same cycle it is looked up. The bench judges it by expecting the old physical page in that response and the new one in the following lookup.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // page-table word bit positions
  localparam int TTE_W      = 64;
  localparam int TTE_VALID  = 63;
  localparam int TTE_SZ_LO  = 61;
  localparam int TTE_NFO    = 60;
  localparam int TTE_USED   = 41;
  localparam int TTE_PPN_HI = 40;
  localparam int TTE_PPN_LO = 13;
  localparam int TTE_LOCK   = 6;
  localparam int TTE_SIDEFX = 3;
  localparam int TTE_PRIV   = 2;
  localparam int TTE_WOK    = 1;

  localparam int PG_SHIFT   = 13;
  localparam int PA_W       = TTE_PPN_HI + 1;

  // fault status layout
  localparam int FS_W       = 11;
  localparam int FS_VALID   = 0;
  localparam int FS_OVF     = 1;
  localparam int FS_WRITE   = 2;
  localparam int FS_PRIVM   = 3;
  localparam int FS_NF      = 4;
  localparam int FS_CT_LO   = 5;
  localparam int FS_FT_LO   = 7;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_NFLOAD = 2'd2,
    ACC_RSVD   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_PRI  = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_NUC  = 2'd2,
    SEL_NUC2 = 2'd3
  } ctx_sel_e;

  typedef enum logic [1:0] {
    TRAP_NONE   = 2'd0,
    TRAP_DFAULT = 2'd1,
    TRAP_PROT   = 2'd2,
    TRAP_MISS   = 2'd3
  } trap_e;

  // number of page-offset bits for a size code
  function automatic logic [4:0] pg_shift(input logic [1:0] sz);
    case (sz)
      2'd1:    pg_shift = 5'd16;
      2'd2:    pg_shift = 5'd19;
      2'd3:    pg_shift = 5'd22;
      default: pg_shift = 5'd13;
    endcase
  endfunction

endpackage

// File: rtl/dtlb_entry_array.sv
module dtlb_entry_array
  import dtlb_pkg::*;
#(
  parameter int NUM_ENT = 64,
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VA_W-1:0]    wr_va,
  input  logic [CTX_W-1:0]   wr_ctx,
  input  logic [TTE_W-1:0]   wr_tte,
  input  logic               used_set,
  input  logic [IDX_W-1:0]   used_idx,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [CTX_W-1:0]   lk_ctx,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [TTE_W-1:0]   rd_tte,
  input  logic [IDX_W-1:0]   hit_idx,
  output logic [TTE_PPN_HI-TTE_PPN_LO:0] hit_ppn,
  output logic [1:0]         hit_sz,
  output logic               hit_priv,
  output logic               hit_wok,
  output logic               hit_sidefx,
  output logic               hit_nfo,
  output logic [NUM_ENT-1:0] match_vec
);

  logic [TTE_W-1:0] tte_all [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [TTE_W-1:0] tte_r, tte_d;
    logic [VA_W-1:0]  vtag_r;
    logic [CTX_W-1:0] ctx_r;
    logic             sel_wr, sel_used, ent_en;
    logic [VA_W-1:0]  off_mask;

    assign sel_wr   = wr_en && (wr_idx == IDX_W'(g));
    assign sel_used = used_set && (used_idx == IDX_W'(g));
    assign ent_en   = sel_wr || sel_used;

    always_comb begin
      tte_d = tte_r;
      if (sel_used) tte_d[TTE_USED] = 1'b1;
      if (sel_wr)   tte_d = wr_tte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tte_r <= '0;
      end else if (ent_en) begin
        tte_r <= tte_d;
      end
    end

    // tags need no reset: the cleared valid bit masks them
    always_ff @(posedge clk) begin
      if (sel_wr) begin
        vtag_r <= wr_va;
        ctx_r  <= wr_ctx;
      end
    end

    assign off_mask = ~({VA_W{1'b1}} << pg_shift(tte_r[TTE_SZ_LO+1:TTE_SZ_LO]));
    assign match_vec[g] = tte_r[TTE_VALID] && (ctx_r == lk_ctx) &&
                          (((vtag_r ^ lk_va) & ~off_mask) == '0);
    assign tte_all[g] = tte_r;
  end

  logic [TTE_W-1:0] sel_tte;
  assign sel_tte    = tte_all[hit_idx];
  assign rd_tte     = tte_all[rd_idx];
  assign hit_ppn    = sel_tte[TTE_PPN_HI:TTE_PPN_LO];
  assign hit_sz     = sel_tte[TTE_SZ_LO+1:TTE_SZ_LO];
  assign hit_priv   = sel_tte[TTE_PRIV];
  assign hit_wok    = sel_tte[TTE_WOK];
  assign hit_sidefx = sel_tte[TTE_SIDEFX];
  assign hit_nfo    = sel_tte[TTE_NFO];

endmodule

// File: rtl/dtlb_hit_pick.sv
module dtlb_hit_pick #(
  parameter int NUM_ENT = 64,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  // scan downward so the lowest matching index is kept last
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dtlb_fault_eval.sv
module dtlb_fault_eval
  import dtlb_pkg::*;
(
  input  acc_kind_e  kind,
  input  logic       user,
  input  logic       pg_priv,
  input  logic       pg_wok,
  input  logic       pg_sidefx,
  input  logic       pg_nfo,
  output logic [3:0] ftype,
  output logic       dfault,
  output logic       prot,
  output logic       wr_ok
);

  logic is_nf, is_st;

  always_comb begin
    is_nf    = (kind == ACC_NFLOAD);
    is_st    = (kind == ACC_STORE);
    ftype    = 4'b0000;
    ftype[0] = pg_priv && user;
    ftype[1] = is_nf && pg_sidefx;
    ftype[2] = !is_nf && pg_nfo;
    dfault   = |ftype;
    prot     = !dfault && is_st && !pg_wok;
    wr_ok    = pg_wok;
  end

endmodule

// File: rtl/dtlb_status.sv
module dtlb_status
  import dtlb_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int CTX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_strobe,
  input  logic             rec_fault,
  input  logic             rec_miss,
  input  logic [3:0]       ftype,
  input  logic [1:0]       ctype,
  input  logic             is_store,
  input  logic             is_nf,
  input  logic             privm,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  output logic [FS_W-1:0]  fstat_q,
  output logic [VA_W-1:0]  faddr_q,
  output logic [VA_W-1:0]  tacc_q
);

  logic [FS_W-1:0] fstat_d;
  logic            prior_valid;
  logic            fstat_en;
  logic [VA_W-1:0] tacc_d;

  always_comb begin
    // a read in this cycle consumes the pending valid bit
    prior_valid = fstat_q[FS_VALID] && !rd_strobe;
    fstat_d     = fstat_q;
    if (rd_strobe) fstat_d[FS_VALID] = 1'b0;
    if (rec_fault) begin
      fstat_d = '0;
      fstat_d[FS_FT_LO+3:FS_FT_LO] = ftype;
      fstat_d[FS_CT_LO+1:FS_CT_LO] = ctype;
      fstat_d[FS_NF]    = is_nf;
      fstat_d[FS_PRIVM] = privm;
      fstat_d[FS_WRITE] = is_store;
      fstat_d[FS_OVF]   = prior_valid;
      fstat_d[FS_VALID] = 1'b1;
    end
    fstat_en = rd_strobe || rec_fault;
    tacc_d   = {va[VA_W-1:PG_SHIFT], PG_SHIFT'(ctx)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstat_q <= '0;
      faddr_q <= '0;
      tacc_q  <= '0;
    end else begin
      if (fstat_en)  fstat_q <= fstat_d;
      if (rec_fault) faddr_q <= va;
      if (rec_miss)  tacc_q  <= tacc_d;
    end
  end

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int NUM_ENT = 64,
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int PPN_W  = TTE_PPN_HI - TTE_PPN_LO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTX_W-1:0]  ctx_primary,
  input  logic [CTX_W-1:0]  ctx_secondary,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_ctx_sel,
  input  logic              req_user,
  input  logic              req_priv,
  input  logic              ent_wr_en,
  input  logic [IDX_W-1:0]  ent_wr_idx,
  input  logic [VA_W-1:0]   ent_wr_va,
  input  logic [CTX_W-1:0]  ent_wr_ctx,
  input  logic [63:0]       ent_wr_tte,
  input  logic [IDX_W-1:0]  ent_rd_idx,
  output logic [63:0]       ent_rd_tte,
  input  logic              fstat_rd,
  output logic              rsp_valid,
  output logic [1:0]        rsp_trap,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic [FS_W-1:0]   fstat_q,
  output logic [VA_W-1:0]   faddr_q,
  output logic [VA_W-1:0]   tacc_q
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  acc_kind_e        kind;
  logic [CTX_W-1:0] lk_ctx;
  logic [1:0]       ctype;

  always_comb begin
    kind = acc_kind_e'(req_kind);
    case (ctx_sel_e'(req_ctx_sel))
      SEL_PRI: begin lk_ctx = ctx_primary;   ctype = 2'd0; end
      SEL_SEC: begin lk_ctx = ctx_secondary; ctype = 2'd1; end
      default: begin lk_ctx = '0;            ctype = 2'd2; end
    endcase
  end

  logic [NUM_ENT-1:0] match_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic [1:0]         hit_sz;
  logic               hit_priv, hit_wok, hit_sidefx, hit_nfo;
  logic [3:0]         ftype;
  logic               dfault, prot, wr_ok;
  logic               used_set, rec_fault, rec_miss;

  dtlb_entry_array #(
    .NUM_ENT(NUM_ENT), .VA_W(VA_W), .CTX_W(CTX_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (ent_wr_en),
    .wr_idx     (ent_wr_idx),
    .wr_va      (ent_wr_va),
    .wr_ctx     (ent_wr_ctx),
    .wr_tte     (ent_wr_tte),
    .used_set   (used_set),
    .used_idx   (hit_idx),
    .lk_va      (req_va),
    .lk_ctx     (lk_ctx),
    .rd_idx     (ent_rd_idx),
    .rd_tte     (ent_rd_tte),
    .hit_idx    (hit_idx),
    .hit_ppn    (hit_ppn),
    .hit_sz     (hit_sz),
    .hit_priv   (hit_priv),
    .hit_wok    (hit_wok),
    .hit_sidefx (hit_sidefx),
    .hit_nfo    (hit_nfo),
    .match_vec  (match_vec)
  );

  dtlb_hit_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .match_vec (match_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  dtlb_fault_eval u_fault (
    .kind      (kind),
    .user      (req_user),
    .pg_priv   (hit_priv),
    .pg_wok    (hit_wok),
    .pg_sidefx (hit_sidefx),
    .pg_nfo    (hit_nfo),
    .ftype     (ftype),
    .dfault    (dfault),
    .prot      (prot),
    .wr_ok     (wr_ok)
  );

  assign used_set  = req_valid && hit && !dfault && !prot;
  assign rec_fault = req_valid && hit && (dfault || prot);
  assign rec_miss  = req_valid && !hit;

  dtlb_status #(.VA_W(VA_W), .CTX_W(CTX_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_strobe (fstat_rd),
    .rec_fault (rec_fault),
    .rec_miss  (rec_miss),
    .ftype     (ftype),
    .ctype     (ctype),
    .is_store  (kind == ACC_STORE),
    .is_nf     (kind == ACC_NFLOAD),
    .privm     (req_priv),
    .va        (req_va),
    .ctx       (lk_ctx),
    .fstat_q   (fstat_q),
    .faddr_q   (faddr_q),
    .tacc_q    (tacc_q)
  );

  // physical address and response next state
  logic [PA_W-1:0] off_pa, pa_d;
  logic [1:0]      trap_d;
  logic            rd_d, wr_d;

  always_comb begin
    off_pa = ~({PA_W{1'b1}} << pg_shift(hit_sz));
    pa_d   = ({hit_ppn, {TTE_PPN_LO{1'b0}}} & ~off_pa) | (req_va[PA_W-1:0] & off_pa);
    trap_d = TRAP_NONE;
    rd_d   = 1'b0;
    wr_d   = 1'b0;
    if (!hit) begin
      trap_d = TRAP_MISS;
      pa_d   = '0;
    end else if (dfault) begin
      trap_d = TRAP_DFAULT;
      pa_d   = '0;
    end else if (prot) begin
      trap_d = TRAP_PROT;
      pa_d   = '0;
    end else begin
      rd_d = 1'b1;
      wr_d = wr_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= TRAP_NONE;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_trap <= trap_d;
        rsp_pa   <= pa_d;
        rsp_rd   <= rd_d;
        rsp_wr   <= wr_d;
      end
    end
  end

endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk
  import dtlb_pkg::*;
#(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fstat_rd,
  input logic            rsp_valid,
  input logic [1:0]      rsp_trap,
  input logic            rsp_rd,
  input logic            rsp_wr,
  input logic [FS_W-1:0] fstat_q,
  input logic [VA_W-1:0] faddr_q
);

  logic fault_rsp;
  assign fault_rsp = rsp_valid && (rsp_trap == TRAP_DFAULT || rsp_trap == TRAP_PROT);

  // R4
  grant_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wr |-> rsp_rd);

  // R4
  trap_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap != TRAP_NONE |-> !rsp_rd && !rsp_wr);

  // R7
  fault_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_rsp |-> fstat_q[FS_VALID]);

  // R5
  dfault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap == TRAP_DFAULT |-> fstat_q[FS_FT_LO+3:FS_FT_LO] != 4'd0);

  // R6
  prot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap == TRAP_PROT |->
      fstat_q[FS_FT_LO+3:FS_FT_LO] == 4'd0 && fstat_q[FS_WRITE]);

  // R8
  overflow_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_rsp |-> fstat_q[FS_OVF] == ($past(fstat_q[FS_VALID]) && !$past(fstat_rd)));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fstat_rd) && !fault_rsp |-> !fstat_q[FS_VALID]);

  // R10
  miss_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap == TRAP_MISS && !$past(fstat_rd) |->
      $stable(fstat_q) && $stable(faddr_q));

endmodule

bind dtlb_xlate dtlb_xlate_chk #(.VA_W(VA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fstat_rd  (fstat_rd),
  .rsp_valid (rsp_valid),
  .rsp_trap  (rsp_trap),
  .rsp_rd    (rsp_rd),
  .rsp_wr    (rsp_wr),
  .fstat_q   (fstat_q),
  .faddr_q   (faddr_q)
);

// File: tb/dtlb_xlate_test.sv
module dtlb_xlate_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ENT = 64;
  localparam int VA_W    = 64;
  localparam int CTX_W   = 13;
  localparam int IDX_W   = 6;
  localparam int PA_W    = 41;

  localparam logic [63:0] F_W    = 64'h2;
  localparam logic [63:0] F_PRIV = 64'h4;
  localparam logic [63:0] F_SFX  = 64'h8;
  localparam logic [63:0] F_NFO  = 64'h1 << 60;

  logic clk = 1'b0;
  logic rst_n;
  logic [CTX_W-1:0] ctx_primary, ctx_secondary;
  logic req_valid;
  logic [VA_W-1:0] req_va;
  logic [1:0] req_kind, req_ctx_sel;
  logic req_user, req_priv;
  logic ent_wr_en;
  logic [IDX_W-1:0] ent_wr_idx, ent_rd_idx;
  logic [VA_W-1:0] ent_wr_va;
  logic [CTX_W-1:0] ent_wr_ctx;
  logic [63:0] ent_wr_tte, ent_rd_tte;
  logic fstat_rd;
  logic rsp_valid, rsp_rd, rsp_wr;
  logic [1:0] rsp_trap;
  logic [PA_W-1:0] rsp_pa;
  logic [10:0] fstat_q;
  logic [VA_W-1:0] faddr_q, tacc_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtlb_xlate #(.NUM_ENT(NUM_ENT), .VA_W(VA_W), .CTX_W(CTX_W)) uut (
    .clk(clk), .rst_n(rst_n), .ctx_primary(ctx_primary), .ctx_secondary(ctx_secondary),
    .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind), .req_ctx_sel(req_ctx_sel),
    .req_user(req_user), .req_priv(req_priv), .ent_wr_en(ent_wr_en), .ent_wr_idx(ent_wr_idx),
    .ent_wr_va(ent_wr_va), .ent_wr_ctx(ent_wr_ctx), .ent_wr_tte(ent_wr_tte),
    .ent_rd_idx(ent_rd_idx), .ent_rd_tte(ent_rd_tte), .fstat_rd(fstat_rd),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd),
    .rsp_wr(rsp_wr), .fstat_q(fstat_q), .faddr_q(faddr_q), .tacc_q(tacc_q)
  );

  typedef struct {
    logic [1:0]      trap;
    logic [PA_W-1:0] pa;
    logic            rd;
    logic            wr;
    int              rq;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  function automatic logic [63:0] mk_tte(input logic [1:0] sz, input logic [27:0] ppn,
                                         input logic [63:0] flags);
    mk_tte = {1'b1, sz, 61'b0} | ({36'b0, ppn} << 13) | flags;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected response actual trap=%0d expected none", rsp_trap);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_trap !== e.trap || rsp_pa !== e.pa || rsp_rd !== e.rd || rsp_wr !== e.wr) begin
          n_fail++;
          $display("FAIL R%0d actual trap=%0d pa=%0h rd=%0b wr=%0b expected trap=%0d pa=%0h rd=%0b wr=%0b",
                   e.rq, rsp_trap, rsp_pa, rsp_rd, rsp_wr, e.trap, e.pa, e.rd, e.wr);
        end
      end
    end
  end

  task automatic wr_ent(input int idx, input logic [63:0] va, input logic [CTX_W-1:0] ctx,
                        input logic [63:0] tte);
    ent_wr_en  = 1'b1;
    ent_wr_idx = IDX_W'(idx);
    ent_wr_va  = va;
    ent_wr_ctx = ctx;
    ent_wr_tte = tte;
    @(negedge clk);
    ent_wr_en  = 1'b0;
  endtask

  // driver: called at a falling edge, returns at the next one
  task automatic lookup(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] sel,
                        input logic user, input logic priv, input logic rd_fs,
                        input logic [1:0] etrap, input logic [PA_W-1:0] epa,
                        input logic erd, input logic ewr, input int rq);
    exp_t e;
    e.trap = etrap; e.pa = epa; e.rd = erd; e.wr = ewr; e.rq = rq;
    exp_q.push_back(e);
    req_valid   = 1'b1;
    req_va      = va;
    req_kind    = kind;
    req_ctx_sel = sel;
    req_user    = user;
    req_priv    = priv;
    fstat_rd    = rd_fs;
    @(negedge clk);
    req_valid   = 1'b0;
    fstat_rd    = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ctx_primary = 13'h055; ctx_secondary = 13'h0aa;
    req_valid = 0; req_va = '0; req_kind = 0; req_ctx_sel = 0; req_user = 0; req_priv = 0;
    ent_wr_en = 0; ent_wr_idx = '0; ent_wr_va = '0; ent_wr_ctx = '0; ent_wr_tte = '0;
    ent_rd_idx = '0; fstat_rd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rsp_valid", {63'b0, rsp_valid}, 64'h0);
    check("R1 fstat", {53'b0, fstat_q}, 64'h0);
    check("R1 faddr", faddr_q, 64'h0);
    check("R1 tacc", tacc_q, 64'h0);
    lookup(64'h0, 2'd0, 2'd0, 0, 1, 0, 2'd3, '0, 0, 0, 1); // R1 empty array misses
    check("R1 tacc after first miss", tacc_q, 64'h55);

    wr_ent(0, 64'h1000_0000, 13'h055, mk_tte(2'd0, 28'h123, F_W));
    wr_ent(1, 64'h8040_0000, 13'h000, mk_tte(2'd3, 28'h400, 64'h0));
    wr_ent(2, 64'h2001_0000, 13'h055, mk_tte(2'd1, 28'h080, F_W));
    wr_ent(3, 64'h3008_0000, 13'h055, mk_tte(2'd2, 28'h400, F_W));
    wr_ent(4, 64'h4000_0000, 13'h055, mk_tte(2'd0, 28'h001, F_PRIV | F_W));
    wr_ent(5, 64'h5000_0000, 13'h0aa, mk_tte(2'd0, 28'h002, F_PRIV | F_SFX));
    wr_ent(6, 64'h6000_0000, 13'h055, mk_tte(2'd0, 28'h003, F_NFO | F_W));
    wr_ent(7, 64'h9000_0000, 13'h055, mk_tte(2'd0, 28'h007, 64'h0));
    wr_ent(8, 64'h9000_0000, 13'h055, mk_tte(2'd0, 28'h008, 64'h0));

    // R2 R4 primary 8 KB hit with write grant
    lookup(64'h1000_0abc, 2'd0, 2'd0, 1, 0, 0, 2'd0, 41'h246abc, 1, 1, 2);
    ent_rd_idx = 6'd0; #1;
    check("R4 used bit set", {63'b0, ent_rd_tte[41]}, 64'h1);
    ent_rd_idx = 6'd2; #1;
    check("R12 read port shows untouched entry", ent_rd_tte, mk_tte(2'd1, 28'h080, F_W));

    // R10 same address via secondary context misses
    lookup(64'h1000_0abc, 2'd0, 2'd1, 1, 0, 0, 2'd3, '0, 0, 0, 10);
    check("R10 tacc secondary", tacc_q, 64'h1000_00aa);
    check("R10 fstat untouched", {53'b0, fstat_q}, 64'h0);

    // R3 page sizes
    lookup(64'h805a_bcde, 2'd0, 2'd2, 0, 1, 0, 2'd0, 41'h9abcde, 1, 0, 3);
    lookup(64'h2001_fedc, 2'd0, 2'd0, 0, 1, 0, 2'd0, 41'h10fedc, 1, 1, 3);
    lookup(64'h300f_1234, 2'd0, 2'd0, 0, 1, 0, 2'd0, 41'h871234, 1, 1, 3);

    // R6 R7 store to read-only nucleus page
    lookup(64'h8041_0008, 2'd1, 2'd3, 0, 1, 0, 2'd2, '0, 0, 0, 6);
    check("R7 fstat protection", {53'b0, fstat_q}, 64'h04d);
    check("R7 faddr", faddr_q, 64'h8041_0008);

    // R5 R8 user access to privileged page, no read in between
    lookup(64'h4000_0010, 2'd0, 2'd0, 1, 0, 0, 2'd1, '0, 0, 0, 5);
    check("R8 overflow set", {53'b0, fstat_q}, 64'h083);

    // R9 read strobe clears valid only
    fstat_rd = 1'b1;
    @(negedge clk);
    fstat_rd = 1'b0;
    check("R9 read clears valid", {53'b0, fstat_q}, 64'h082);

    // R5 two causes together, secondary no-fault load
    lookup(64'h5000_0040, 2'd2, 2'd1, 1, 0, 0, 2'd1, '0, 0, 0, 5);
    check("R5 combined causes", {53'b0, fstat_q}, 64'h1b1);
    check("R7 faddr second", faddr_q, 64'h5000_0040);

    // R5 no-fault load to a no-fault-only page is allowed
    lookup(64'h6000_0010, 2'd2, 2'd0, 0, 1, 0, 2'd0, 41'h6010, 1, 1, 5);
    check("R5 clean hit keeps status", {53'b0, fstat_q}, 64'h1b1);

    // R9 read in the same cycle as a fault on a no-fault-only page
    lookup(64'h6000_0020, 2'd1, 2'd0, 0, 1, 1, 2'd1, '0, 0, 0, 9);
    check("R9 collision fstat", {53'b0, fstat_q}, 64'h20d);

    // R10 miss leaves status and address
    lookup(64'h7777_0000, 2'd0, 2'd0, 0, 1, 0, 2'd3, '0, 0, 0, 10);
    check("R10 tacc", tacc_q, 64'h7777_0055);
    check("R10 fstat kept", {53'b0, fstat_q}, 64'h20d);
    check("R10 faddr kept", faddr_q, 64'h6000_0020);

    // R11 two entries hit, lowest index wins
    lookup(64'h9000_0004, 2'd0, 2'd0, 0, 1, 0, 2'd0, 41'he004, 1, 0, 11);

    // R12 invalidate entry 7, entry 8 then answers
    wr_ent(7, 64'h9000_0000, 13'h055, 64'h0);
    lookup(64'h9000_0004, 2'd0, 2'd0, 0, 1, 0, 2'd0, 41'h10004, 1, 0, 12);

    // R12 rewrite in the same cycle as a lookup: old contents answer
    ent_wr_en  = 1'b1;
    ent_wr_idx = 6'd8;
    ent_wr_va  = 64'h9000_0000;
    ent_wr_ctx = 13'h055;
    ent_wr_tte = mk_tte(2'd0, 28'h009, 64'h0);
    lookup(64'h9000_0004, 2'd0, 2'd0, 0, 1, 0, 2'd0, 41'h10004, 1, 0, 12);
    ent_wr_en  = 1'b0;
    lookup(64'h9000_0004, 2'd0, 2'd0, 0, 1, 0, 2'd0, 41'h12004, 1, 0, 12);

    repeat (2) @(negedge clk);
    check("R2 all responses seen", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule